// File: doc/BRIEF.md
# Event-Coded Receiver Clock with Time-Tagged Event Log

This block keeps wall-clock time on the receiving end of an event link. Whole seconds are not carried by a wire. They arrive one bit at a time as two dedicated event codes, one for a 0 and one for a 1. The bits collect in a staging shift register. A third code commits the staged value as the current seconds and clears the sub-second counter. That counter advances on one of three selectable ticks: a divided event clock, rising edges of one distributed-bus bit, or arrivals of a dedicated tick code.

The receiver's event mapping supplies two strobes alongside each event. One strobe snapshots the present seconds and sub-second count into a pair of output registers. The other appends a record of seconds, sub-second count and event code to a 511-deep log. A host drains the log through a one-word-per-request read port.

Top module: `evts_core`

## Requirements
- R1: An event with code 0x70 shifts a 0 into the LSB of the 32-bit staging register and code 0x71 shifts in a 1. The register moves toward its MSB, so the bit received first ends as the MSB of the seconds value. Shifting alone leaves the committed seconds unchanged.
- R2: Code 0x7D copies the staging register into the seconds register and sets the sub-second counter to 0 at the same edge. The staging register keeps its contents. The prescaler restarts at 0.
- R3: `src_sel` picks the sub-second tick. 0 gives one tick every `presc_div` cycles, with a value of 0 acting as 1. 1 gives one tick per rising edge of `dbus_bit`, seen through a two-flop synchroniser. 2 gives one tick per event with code 0x7C. 3 holds the counter. Ticks from unselected sources have no effect.
- R4: `latch_stb` with `ev_valid` copies the seconds and sub-second values present before that edge's update into `lat_sec` and `lat_ts`.
- R5: `log_stb` with `ev_valid` appends a record holding the pre-update seconds, the pre-update sub-second count and `ev_code`. Strobes without `ev_valid` are ignored.
- R6: The log holds 511 records. `fifo_count` gives the occupancy, `fifo_full` is high at 511 and `fifo_empty` is high at 0.
- R7: An append to a full log with no simultaneous pop is dropped and sets the sticky `fifo_ovf`. A pulse on `ovf_clr` clears the flag, and a new drop in the same cycle wins over the clear.
- R8: `rd_data` presents the oldest record as three words, in this order: seconds (`rd_word`=0), sub-second count (1), and the code zero-extended (2). Each `rd_req` advances the word. The request on word 2 pops the record and returns to word 0. `rd_req` on an empty log is ignored, and `rd_data` reads 0 while the log is empty.
- R9: After reset the latches are 0, the log is empty, the overflow flag is clear and `rd_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_valid | input | 1 | Event code strobe |
| ev_code | input | 8 | Received event code |
| latch_stb | input | 1 | Map strobe: snapshot time |
| log_stb | input | 1 | Map strobe: append record to log |
| dbus_bit | input | 1 | Distributed-bus bit used as tick source |
| src_sel | input | 2 | Tick source select |
| presc_div | input | PRESC_W (16) | Event-clock divide ratio |
| rd_req | input | 1 | Host read request, one word per cycle |
| ovf_clr | input | 1 | Clear sticky overflow |
| lat_sec | output | 32 | Latched seconds |
| lat_ts | output | 32 | Latched sub-second count |
| rd_data | output | 32 | Current word of oldest record |
| rd_word | output | 2 | Index of word shown on rd_data |
| fifo_count | output | CNT_W (9) | Records held |
| fifo_empty | output | 1 | Log empty |
| fifo_full | output | 1 | Log full |
| fifo_ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that the map strobes are meaningful only in a cycle with `ev_valid` and that they belong to the code on `ev_code` in that same cycle. They also assume that `rd_req` comes from a host that watches `fifo_empty`, and that `src_sel` and `presc_div` stay constant while the counter is being measured. The stimulus raises every strobe together with its event in one cycle. Each invalid-strobe case is a separate, deliberate test, and its effect is checked at the ports. The tick source is reprogrammed only before a commit code, so every sub-second measurement starts from a known zero.

// File: rtl/evts_pkg.sv
package evts_pkg;
  localparam int SEC_W  = 32;
  localparam int TS_W   = 32;
  localparam int CODE_W = 8;

  localparam logic [CODE_W-1:0] CODE_BIT0 = 8'h70;
  localparam logic [CODE_W-1:0] CODE_BIT1 = 8'h71;
  localparam logic [CODE_W-1:0] CODE_TICK = 8'h7C;
  localparam logic [CODE_W-1:0] CODE_LOAD = 8'h7D;

  typedef enum logic [1:0] {
    SRC_PRESC = 2'd0,
    SRC_DBUS  = 2'd1,
    SRC_CODE  = 2'd2,
    SRC_HOLD  = 2'd3
  } tick_src_e;

  typedef enum logic [1:0] {
    W_SEC  = 2'd0,
    W_TS   = 2'd1,
    W_CODE = 2'd2
  } rd_word_e;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [TS_W-1:0]   ts;
    logic [CODE_W-1:0] code;
  } ev_rec_t;

  localparam int REC_W = SEC_W + TS_W + CODE_W;
endpackage

// File: rtl/evts_seconds.sv
module evts_seconds
  import evts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [CODE_W-1:0] ev_code,
  output logic [SEC_W-1:0]  sec_o,
  output logic              load_o
);
  logic [SEC_W-1:0] sr_q, sr_d;
  logic [SEC_W-1:0] sec_q, sec_d;

  assign load_o = ev_valid && (ev_code == CODE_LOAD);
  assign sec_o  = sec_q;

  always_comb begin
    sr_d  = sr_q;
    sec_d = sec_q;
    if (ev_valid) begin
      unique case (ev_code)
        CODE_BIT0: sr_d  = {sr_q[SEC_W-2:0], 1'b0};
        CODE_BIT1: sr_d  = {sr_q[SEC_W-2:0], 1'b1};
        CODE_LOAD: sec_d = sr_q;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      sec_q <= '0;
    end else begin
      sr_q  <= sr_d;
      sec_q <= sec_d;
    end
  end

  assert_shift_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_code == CODE_BIT1) |=> (sr_q == {$past(sr_q[SEC_W-2:0]), 1'b1}));

  assert_shift_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_code == CODE_BIT0) |=> (sr_q == {$past(sr_q[SEC_W-2:0]), 1'b0}));

  assert_load_sec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (sec_q == $past(sr_q)));
endmodule

// File: rtl/evts_tick.sv
module evts_tick
  import evts_pkg::*;
#(
  parameter int PRESC_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         src_sel,
  input  logic [PRESC_W-1:0] presc_div,
  input  logic               dbus_bit,
  input  logic               ev_valid,
  input  logic [CODE_W-1:0]  ev_code,
  input  logic               restart,
  output logic               tick
);
  logic [PRESC_W-1:0]   pcnt_q, pcnt_d;
  logic [PRESC_W-1:0]   div_last;
  logic                 presc_hit;
  logic [SYNC_STAGES:0] sync_q;
  logic                 dbus_rise;
  tick_src_e            src;

  assign src       = tick_src_e'(src_sel);
  assign div_last  = (presc_div == '0) ? '0 : presc_div - 1'b1;
  assign presc_hit = (pcnt_q >= div_last);
  assign dbus_rise = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];

  always_comb begin
    if (restart || src != SRC_PRESC || presc_hit) pcnt_d = '0;
    else                                          pcnt_d = pcnt_q + 1'b1;
  end

  always_comb begin
    unique case (src)
      SRC_PRESC: tick = presc_hit;
      SRC_DBUS:  tick = dbus_rise;
      SRC_CODE:  tick = ev_valid && (ev_code == CODE_TICK);
      default:   tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      sync_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      sync_q <= {sync_q[SYNC_STAGES-1:0], dbus_bit};
    end
  end

  assert_presc_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pcnt_q == '0));
endmodule

// File: rtl/evts_fifo.sv
module evts_fifo
  import evts_pkg::*;
#(
  parameter int DEPTH = 511,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  ev_rec_t          push_rec,
  input  logic             pop,
  input  logic             ovf_clr,
  output ev_rec_t          head_rec,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             ovf
);
  ev_rec_t          mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             accept, drop, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign do_pop   = pop && !empty;
  assign accept   = push && (!full || do_pop);
  assign drop     = push && !accept;
  assign head_rec = mem[rd_q];
  assign count    = cnt_q;
  assign ovf      = ovf_q;

  always_comb begin
    wr_d  = accept ? ptr_inc(wr_q) : wr_q;
    rd_d  = do_pop ? ptr_inc(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (accept && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (!accept && do_pop) cnt_d = cnt_q - 1'b1;
    ovf_d = ovf_q;
    if (ovf_clr) ovf_d = 1'b0;
    if (drop)    ovf_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_q] <= push_rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  assert_drop_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q)) && ovf_q);

  assert_pop_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/evts_core.sv
module evts_core
  import evts_pkg::*;
#(
  parameter int PRESC_W     = 16,
  parameter int DEPTH       = 511,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  input  logic [7:0]         ev_code,
  input  logic               latch_stb,
  input  logic               log_stb,
  input  logic               dbus_bit,
  input  logic [1:0]         src_sel,
  input  logic [PRESC_W-1:0] presc_div,
  input  logic               rd_req,
  input  logic               ovf_clr,
  output logic [31:0]        lat_sec,
  output logic [31:0]        lat_ts,
  output logic [31:0]        rd_data,
  output logic [1:0]         rd_word,
  output logic [CNT_W-1:0]   fifo_count,
  output logic               fifo_empty,
  output logic               fifo_full,
  output logic               fifo_ovf
);
  logic [1:0]       rsync_q;
  logic             rst_s;
  logic [SEC_W-1:0] sec;
  logic             load;
  logic             tick;
  logic [TS_W-1:0]  ts_q, ts_d;
  logic [SEC_W-1:0] lsec_q, lsec_d;
  logic [TS_W-1:0]  lts_q, lts_d;
  rd_word_e         widx_q, widx_d;
  logic             pop;
  ev_rec_t          head, rec_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  evts_seconds u_sec (
    .clk(clk), .rst_n(rst_s), .ev_valid(ev_valid), .ev_code(ev_code),
    .sec_o(sec), .load_o(load)
  );

  evts_tick #(.PRESC_W(PRESC_W), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_s), .src_sel(src_sel), .presc_div(presc_div),
    .dbus_bit(dbus_bit), .ev_valid(ev_valid), .ev_code(ev_code),
    .restart(load), .tick(tick)
  );

  assign rec_in = '{sec: sec, ts: ts_q, code: ev_code};
  assign pop    = rd_req && !fifo_empty && (widx_q == W_CODE);

  evts_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s), .push(ev_valid && log_stb), .push_rec(rec_in),
    .pop(pop), .ovf_clr(ovf_clr), .head_rec(head), .count(fifo_count),
    .full(fifo_full), .empty(fifo_empty), .ovf(fifo_ovf)
  );

  always_comb begin
    ts_d = ts_q;
    if (load)      ts_d = '0;
    else if (tick) ts_d = ts_q + 1'b1;
    lsec_d = lsec_q;
    lts_d  = lts_q;
    if (ev_valid && latch_stb) begin
      lsec_d = sec;
      lts_d  = ts_q;
    end
    widx_d = widx_q;
    if (rd_req && !fifo_empty)
      widx_d = (widx_q == W_CODE) ? W_SEC : rd_word_e'(widx_q + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ts_q   <= '0;
      lsec_q <= '0;
      lts_q  <= '0;
      widx_q <= W_SEC;
    end else begin
      ts_q   <= ts_d;
      lsec_q <= lsec_d;
      lts_q  <= lts_d;
      widx_q <= widx_d;
    end
  end

  always_comb begin
    if (fifo_empty) rd_data = '0;
    else begin
      unique case (widx_q)
        W_SEC:   rd_data = head.sec;
        W_TS:    rd_data = head.ts;
        default: rd_data = {{(32-CODE_W){1'b0}}, head.code};
      endcase
    end
  end

  assign lat_sec = lsec_q;
  assign lat_ts  = lts_q;
  assign rd_word = widx_q;

  assert_load_clears_ts_R2: assert property (@(posedge clk) disable iff (!rst_s)
    load |=> (ts_q == '0));

  assert_latch_pre_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (ev_valid && latch_stb) |=> (lat_sec == $past(sec)) && (lat_ts == $past(ts_q)));

  assert_word_wrap_R8: assert property (@(posedge clk) disable iff (!rst_s)
    pop |=> (rd_word == W_SEC));
endmodule

// File: tb/evts_core_tb.sv
module evts_core_tb;
  localparam int DEPTH = 511;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 0, latch_stb = 0, log_stb = 0, dbus_bit = 0, rd_req = 0, ovf_clr = 0;
  logic [7:0] ev_code = 0;
  logic [1:0] src_sel = 2'd2;
  logic [15:0] presc_div = 16'd1;
  logic [31:0] lat_sec, lat_ts, rd_data;
  logic [1:0] rd_word;
  logic [CNT_W-1:0] fifo_count;
  logic fifo_empty, fifo_full, fifo_ovf;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] e_sr = 0, e_sec = 0, e_ts = 0, e_lsec = 0, e_lts = 0;
  int e_cnt = 0;
  bit e_ovf = 0;
  logic [71:0] sb_q[$];

  always #4 clk = ~clk;

  evts_core u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .latch_stb(latch_stb), .log_stb(log_stb), .dbus_bit(dbus_bit),
    .src_sel(src_sel), .presc_div(presc_div), .rd_req(rd_req), .ovf_clr(ovf_clr),
    .lat_sec(lat_sec), .lat_ts(lat_ts), .rd_data(rd_data), .rd_word(rd_word),
    .fifo_count(fifo_count), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_ovf(fifo_ovf)
  );

  task automatic check(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // driver: one event per cycle, models expected state and feeds the scoreboard
  task automatic send(input bit v, input logic [7:0] c, input bit lat, input bit lg);
    ev_valid = v; ev_code = c; latch_stb = lat; log_stb = lg;
    if (v) begin
      if (lat) begin e_lsec = e_sec; e_lts = e_ts; end
      if (lg) begin
        if (e_cnt < DEPTH) begin sb_q.push_back({e_sec, e_ts, c}); e_cnt++; end
        else e_ovf = 1;
      end
      case (c)
        8'h70: e_sr = {e_sr[30:0], 1'b0};
        8'h71: e_sr = {e_sr[30:0], 1'b1};
        8'h7D: begin e_sec = e_sr; e_ts = 0; end
        8'h7C: if (src_sel == 2'd2) e_ts = e_ts + 1;
        default: ;
      endcase
    end
    @(negedge clk);
    ev_valid = 0; latch_stb = 0; log_stb = 0; ev_code = 0;
  endtask

  task automatic idle(input int m);
    repeat (m) @(negedge clk);
  endtask

  task automatic read_word(output logic [31:0] v);
    v = rd_data;
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
  endtask

  // monitor: pops the oldest expected record and compares the three words
  task automatic read_record();
    logic [71:0] exp;
    logic [31:0] w;
    exp = sb_q.pop_front();
    check("R8 word index 0", rd_word == 2'd0, rd_word, 0);
    read_word(w); check("R8 seconds word", w == exp[71:40], w, exp[71:40]);
    read_word(w); check("R8 subsecond word", w == exp[39:8], w, exp[39:8]);
    read_word(w); check("R8 code word", w == {24'd0, exp[7:0]}, w, {24'd0, exp[7:0]});
    e_cnt--;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] pat;
    logic [31:0] w;
    idle(3);
    rst_n = 1;
    idle(4);
    // R9 reset state
    check("R9 lat_sec", lat_sec == 0, lat_sec, 0);
    check("R9 lat_ts", lat_ts == 0, lat_ts, 0);
    check("R9 empty", fifo_empty && fifo_count == 0, fifo_count, 0);
    check("R9 ovf and word", !fifo_ovf && rd_word == 0, {fifo_ovf, rd_word}, 0);

    // R1 serial seconds, MSB first; shifting alone leaves seconds untouched
    pat = 32'hA5C3_0F1E;
    for (int i = 31; i >= 0; i--) send(1, pat[i] ? 8'h71 : 8'h70, 0, 0);
    send(1, 8'h00, 1, 0);
    check("R1 seconds unchanged by shift", lat_sec == 0, lat_sec, 0);
    send(1, 8'h7D, 0, 0);
    send(1, 8'h00, 1, 0);
    check("R2 seconds committed", lat_sec == pat && lat_sec == e_lsec, lat_sec, pat);
    // R1 further bits continue from staged value
    send(1, 8'h71, 0, 0); send(1, 8'h70, 0, 0); send(1, 8'h7D, 0, 0);
    send(1, 8'h00, 1, 0);
    check("R1 shift continues after load", lat_sec == {pat[29:0], 2'b10}, lat_sec, {pat[29:0], 2'b10});

    // R3 code ticks, R4 pre-update latch
    src_sel = 2'd2;
    send(1, 8'h7D, 0, 0);
    repeat (5) send(1, 8'h7C, 0, 0);
    send(1, 8'h7C, 1, 0);
    check("R4 latch sees pre-update ts", lat_ts == 5 && lat_ts == e_lts, lat_ts, 5);
    send(1, 8'h00, 1, 0);
    check("R3 code tick count", lat_ts == 6, lat_ts, 6);
    // R4 strobe without valid ignored
    send(1, 8'h7C, 0, 0);
    send(0, 8'h00, 1, 0);
    check("R4 strobe without valid ignored", lat_ts == 6, lat_ts, 6);
    // R2 load clears ts
    send(1, 8'h7D, 0, 0);
    send(1, 8'h00, 1, 0);
    check("R2 ts cleared by load", lat_ts == 0, lat_ts, 0);

    // R3 dbus pulses ignored while code source selected
    dbus_bit = 1; idle(4); dbus_bit = 0; idle(4);
    send(1, 8'h00, 1, 0);
    check("R3 dbus ignored in code mode", lat_ts == 0, lat_ts, 0);

    // R3 prescaler divide by 4
    src_sel = 2'd0; presc_div = 16'd4;
    send(1, 8'h7D, 0, 0);
    idle(21);
    send(1, 8'h00, 1, 0);
    check("R3 prescaler div4", lat_ts == 5, lat_ts, 5);
    // R3 divide value 0 acts as 1
    presc_div = 16'd0;
    send(1, 8'h7D, 0, 0);
    idle(5);
    send(1, 8'h00, 1, 0);
    check("R3 prescaler div0", lat_ts == 5, lat_ts, 5);

    // R3 dbus rising edges
    src_sel = 2'd1;
    idle(4);
    send(1, 8'h7D, 0, 0);
    for (int k = 0; k < 3; k++) begin dbus_bit = 1; idle(4); dbus_bit = 0; idle(4); end
    send(1, 8'h00, 1, 0);
    check("R3 dbus edge count", lat_ts == 3, lat_ts, 3);

    // R3 hold
    src_sel = 2'd3;
    send(1, 8'h7D, 0, 0);
    send(1, 8'h7C, 0, 0); idle(6);
    send(1, 8'h00, 1, 0);
    check("R3 hold source", lat_ts == 0, lat_ts, 0);

    // R5 log records under code ticks; scoreboard compares
    src_sel = 2'd2;
    send(1, 8'h7D, 0, 0); e_ts = 0;
    send(1, 8'h7C, 0, 1);
    send(1, 8'h42, 0, 1);
    send(0, 8'h55, 0, 1);
    send(1, 8'h7C, 1, 1);
    check("R5 count after logs", fifo_count == 3 && fifo_count == e_cnt, fifo_count, 3);
    check("R6 not empty", !fifo_empty, fifo_empty, 0);
    read_word(w);
    check("R8 partial read keeps record", fifo_count == 3 && rd_word == 1, {fifo_count, rd_word}, {9'd3, 2'd1});
    read_word(w); read_word(w);
    check("R8 pop on third word", fifo_count == 2 && rd_word == 0, {fifo_count, rd_word}, {9'd2, 2'd0});
    void'(sb_q.pop_front()); e_cnt--;
    while (sb_q.size() > 0) read_record();
    check("R6 empty after drain", fifo_empty && fifo_count == 0, fifo_count, 0);
    // R8 empty read ignored
    read_word(w);
    check("R8 empty read data", w == 0, w, 0);
    check("R8 empty read ignored", rd_word == 0 && fifo_count == 0, {fifo_count, rd_word}, 0);

    // R6/R7 fill, overflow, clear
    for (int k = 0; k < DEPTH; k++) send(1, 8'(k), 0, 1);
    check("R6 full at depth", fifo_full && fifo_count == DEPTH, fifo_count, DEPTH);
    check("R7 no ovf at exact depth", !fifo_ovf, fifo_ovf, 0);
    send(1, 8'hEE, 0, 1);
    check("R7 drop on full", fifo_count == DEPTH && fifo_ovf && e_ovf, {fifo_ovf, fifo_count}, {1'b1, 9'(DEPTH)});
    ovf_clr = 1; idle(1); ovf_clr = 0;
    check("R7 ovf cleared", !fifo_ovf, fifo_ovf, 0);
    // R7 drop and clear together: set wins
    ovf_clr = 1;
    send(1, 8'hEF, 0, 1);
    ovf_clr = 0;
    check("R7 set wins over clear", fifo_ovf, fifo_ovf, 1);
    while (sb_q.size() > 0) read_record();
    check("R6 empty after full drain", fifo_empty, fifo_empty, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule